// File: doc/BRIEF.md
# PS/2 Device-Side Frame Receiver

This block sits on the device end of a two-wire PS/2 link and takes in bytes sent by the host. Both lines are open-collector. The block reads the two lines through synchronizers. It pulls a line low through a drive-enable output and releases it by deasserting that output.

The host asks to send by inhibiting the link: it holds CLK low long enough, then releases CLK while holding DATA low as the start bit. The block then generates the link clock itself. It shifts in eight data bits (LSB first), a parity bit and a stop bit. If the stop bit is high, it drives DATA low and gives an eleventh clock as the line-control acknowledge. If the stop bit is low, it keeps clocking until DATA is seen high, and only then gives the acknowledge clock. On any framing or parity problem it pulses a resend request instead of a valid strobe.

A local transmitter asks for the link through a request input. The grant is given only while the receiver is idle and both lines are high, so a pending host request-to-send always wins.

Top module: `ps2_dev_rx`

## Requirements
- R1: After reset the block drives neither line, and `rx_valid_o`, `resend_o`, `frame_err_o` and `rx_byte_o` are all zero.
- R2: A request-to-send is accepted only after the synchronized CLK has been low for at least `INHIBIT_CYC` system clocks and is then released while DATA is low. A shorter low pulse on CLK is ignored, and the block generates no clock in response.
- R3: Each generated clock has a released (high) phase and a driven-low phase of `HALF_CYC` system clocks each. DATA is sampled at the end of each low phase. Clocks 1 to 8 carry data bits 0 to 7, LSB first.
- R4: Clock 9 carries the parity bit. The frame passes parity when the eight data bits plus the parity bit hold an odd number of ones.
- R5: If DATA is high when clock 10 is sampled, the block drives DATA low, issues an eleventh clock while DATA stays low, and releases DATA after that clock. A good frame therefore has exactly 11 falling CLK edges.
- R6: If DATA is low when clock 10 is sampled (framing error), the block keeps issuing clocks until DATA is sampled high, then issues the acknowledge clock. With E clocks sampled low from clock 10 on, the frame has 11+E clocks. The block then pulses `resend_o` and `frame_err_o` together for one cycle.
- R7: When both the stop bit and parity pass, `rx_valid_o` pulses for one cycle with the byte on `rx_byte_o`, and `resend_o` stays low.
- R8: On a parity failure with a good stop bit, `resend_o` pulses for one cycle with `frame_err_o` low, `rx_valid_o` stays low, and `rx_byte_o` keeps its previous value.
- R9: `tx_grant_o` is high only when `tx_req_i` is high, the receiver is idle, and both synchronized lines are high. It is low throughout a reception and while the host inhibits the link or requests to send.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ps2_clk_i | input | 1 | Sensed level of the CLK line |
| ps2_data_i | input | 1 | Sensed level of the DATA line |
| ps2_clk_drive_o | output | 1 | 1 pulls the CLK line low |
| ps2_data_drive_o | output | 1 | 1 pulls the DATA line low |
| tx_req_i | input | 1 | Local transmitter wants the link |
| tx_grant_o | output | 1 | Link free for the transmitter |
| rx_byte_o | output | 8 | Last byte received without error |
| rx_valid_o | output | 1 | One-cycle strobe for a good byte |
| resend_o | output | 1 | One-cycle resend request on a bad frame |
| frame_err_o | output | 1 | Marks the resend as a stop-bit failure |

## Verification
The assertions assume that `INHIBIT_CYC` exceeds `HALF_CYC`, so the block's own driven-low phases can never look like a host inhibit. They also assume the host changes DATA only around the falling CLK edges the block generates, well ahead of the end of each low phase. The bench host model keeps to this: it updates DATA a fraction of a system clock after each falling CLK edge, holds the inhibit either well past or well short of the threshold, and leaves the lines released between frames.

// File: rtl/ps2_rx_pkg.sv
package ps2_rx_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_HI,
    S_LO,
    S_ACK_HI,
    S_ACK_LO,
    S_ACK_REL
  } rx_state_e;

  function automatic logic drives_clk(rx_state_e s);
    return (s == S_LO) || (s == S_ACK_LO);
  endfunction

  function automatic logic drives_data(rx_state_e s);
    return (s == S_ACK_HI) || (s == S_ACK_LO) || (s == S_ACK_REL);
  endfunction
endpackage

// File: rtl/ps2_rts_detect.sv
module ps2_rts_detect #(
  parameter int INHIBIT_CYC = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ps2_clk_i,
  input  logic ps2_data_i,
  output logic clk_s_o,
  output logic data_s_o,
  output logic rts_o
);
  localparam int CNT_W = $clog2(INHIBIT_CYC + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(INHIBIT_CYC);

  logic [SYNC_STAGES-1:0] clk_sync_q, data_sync_q;
  logic [CNT_W-1:0] low_cnt_q;

  generate
    if (SYNC_STAGES == 1) begin : g_sync1
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_sync_q  <= '1;
          data_sync_q <= '1;
        end else begin
          clk_sync_q  <= ps2_clk_i;
          data_sync_q <= ps2_data_i;
        end
      end
    end else begin : g_syncn
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          clk_sync_q  <= '1;
          data_sync_q <= '1;
        end else begin
          clk_sync_q  <= {clk_sync_q[SYNC_STAGES-2:0], ps2_clk_i};
          data_sync_q <= {data_sync_q[SYNC_STAGES-2:0], ps2_data_i};
        end
      end
    end
  endgenerate

  assign clk_s_o  = clk_sync_q[SYNC_STAGES-1];
  assign data_s_o = data_sync_q[SYNC_STAGES-1];

  // saturating count of CLK-low cycles; cleared whenever CLK is high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           low_cnt_q <= '0;
    else if (clk_s_o)      low_cnt_q <= '0;
    else if (low_cnt_q != CNT_MAX) low_cnt_q <= low_cnt_q + 1'b1;
  end

  assign rts_o = clk_s_o && !data_s_o && (low_cnt_q == CNT_MAX);
endmodule

// File: rtl/ps2_half_timer.sv
module ps2_half_timer #(
  parameter int HALF_CYC = 2000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CNT_W = $clog2(HALF_CYC + 1);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(HALF_CYC - 1);

  logic [CNT_W-1:0] cnt_q;

  assign tick_o = en_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!en_i || tick_o) cnt_q <= '0;
    else                      cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/ps2_rx_shift.sv
module ps2_rx_shift #(
  parameter int DATA_W = 8,
  parameter int IDX_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              sample_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              bit_i,
  output logic [DATA_W-1:0] data_o,
  output logic              par_ok_o
);
  localparam logic [IDX_W-1:0] PAR_IDX = IDX_W'(DATA_W);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_o   <= '0;
      par_ok_o <= 1'b0;
    end else if (clr_i) begin
      data_o   <= '0;
      par_ok_o <= 1'b0;
    end else if (sample_i) begin
      if (idx_i < PAR_IDX)       data_o   <= {bit_i, data_o[DATA_W-1:1]};
      else if (idx_i == PAR_IDX) par_ok_o <= ^{data_o, bit_i};
    end
  end
endmodule

// File: rtl/ps2_dev_rx.sv
module ps2_dev_rx
  import ps2_rx_pkg::*;
#(
  parameter int HALF_CYC    = 2000,
  parameter int INHIBIT_CYC = 5000,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ps2_clk_i,
  input  logic       ps2_data_i,
  output logic       ps2_clk_drive_o,
  output logic       ps2_data_drive_o,
  input  logic       tx_req_i,
  output logic       tx_grant_o,
  output logic [7:0] rx_byte_o,
  output logic       rx_valid_o,
  output logic       resend_o,
  output logic       frame_err_o
);
  localparam int DATA_W = 8;
  localparam int IDX_W  = $clog2(DATA_W + 3);
  localparam logic [IDX_W-1:0] STOP_IDX = IDX_W'(DATA_W + 1);

  rx_state_e state_q, state_d;
  logic clk_s, data_s, rts, tick, sample;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic ferr_q, ferr_d;
  logic [DATA_W-1:0] shift_data;
  logic par_ok;

  ps2_rts_detect #(.INHIBIT_CYC(INHIBIT_CYC), .SYNC_STAGES(SYNC_STAGES)) u_rts (
    .clk_i, .rst_ni, .ps2_clk_i, .ps2_data_i,
    .clk_s_o(clk_s), .data_s_o(data_s), .rts_o(rts)
  );

  ps2_half_timer #(.HALF_CYC(HALF_CYC)) u_timer (
    .clk_i, .rst_ni, .en_i(state_q != S_IDLE), .tick_o(tick)
  );

  assign sample = (state_q == S_LO) && tick;

  ps2_rx_shift #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_shift (
    .clk_i, .rst_ni,
    .clr_i(rts && state_q == S_IDLE), .sample_i(sample), .idx_i(idx_q),
    .bit_i(data_s), .data_o(shift_data), .par_ok_o(par_ok)
  );

  always_comb begin
    state_d = state_q;
    idx_d   = idx_q;
    ferr_d  = ferr_q;
    unique case (state_q)
      S_IDLE: if (rts) begin
        state_d = S_HI;
        idx_d   = '0;
        ferr_d  = 1'b0;
      end
      S_HI:   if (tick) state_d = S_LO;
      S_LO: if (tick) begin
        if (idx_q < STOP_IDX) begin
          idx_d   = idx_q + 1'b1;
          state_d = S_HI;
        end else if (data_s) begin
          state_d = S_ACK_HI;
        end else begin
          ferr_d  = 1'b1;   // keep clocking until DATA returns high
          state_d = S_HI;
        end
      end
      S_ACK_HI:  if (tick) state_d = S_ACK_LO;
      S_ACK_LO:  if (tick) state_d = S_ACK_REL;
      S_ACK_REL: if (tick) state_d = S_IDLE;
      default:   state_d = S_IDLE;
    endcase
  end

  logic done;
  assign done = (state_q == S_ACK_REL) && tick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q          <= S_IDLE;
      idx_q            <= '0;
      ferr_q           <= 1'b0;
      ps2_clk_drive_o  <= 1'b0;
      ps2_data_drive_o <= 1'b0;
      rx_byte_o        <= '0;
      rx_valid_o       <= 1'b0;
      resend_o         <= 1'b0;
      frame_err_o      <= 1'b0;
    end else begin
      state_q          <= state_d;
      idx_q            <= idx_d;
      ferr_q           <= ferr_d;
      ps2_clk_drive_o  <= drives_clk(state_d);
      ps2_data_drive_o <= drives_data(state_d);
      rx_valid_o       <= done && !ferr_q && par_ok;
      resend_o         <= done && (ferr_q || !par_ok);
      frame_err_o      <= done && ferr_q;
      if (done && !ferr_q && par_ok) rx_byte_o <= shift_data;
    end
  end

  assign tx_grant_o = tx_req_i && (state_q == S_IDLE) && clk_s && data_s;

  assert_result_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> !resend_o);
  assert_frame_err_resend_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> resend_o);
  assert_valid_after_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rx_valid_o) |-> $past(ps2_data_drive_o));
  assert_rts_only_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rts |-> state_q == S_IDLE);
  assert_grant_line_free_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_grant_o |-> !ps2_clk_drive_o && !ps2_data_drive_o);
endmodule

// File: tb/ps2_dev_rx_test.sv
`timescale 1ns/1ps
module ps2_dev_rx_test;
  localparam int HALF = 10;
  localparam int INH  = 40;

  typedef struct { logic [7:0] b; int kind; } exp_t; // kind 0 good, 1 parity, 2 frame

  logic clk = 0, rst_n = 0;
  logic host_clk = 0, host_data = 0, tx_req = 0;
  logic clk_drv, data_drv, grant, valid, resend, ferr;
  logic [7:0] rbyte;
  wire clk_line  = ~(host_clk | clk_drv);
  wire data_line = ~(host_data | data_drv);

  int n_checks = 0, n_fail = 0, fall_cnt = 0;
  exp_t exp_q[$];
  logic [7:0] last_good = 8'h00;

  always #10 clk = ~clk;

  ps2_dev_rx #(.HALF_CYC(HALF), .INHIBIT_CYC(INH)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ps2_clk_i(clk_line), .ps2_data_i(data_line),
    .ps2_clk_drive_o(clk_drv), .ps2_data_drive_o(data_drv),
    .tx_req_i(tx_req), .tx_grant_o(grant), .rx_byte_o(rbyte),
    .rx_valid_o(valid), .resend_o(resend), .frame_err_o(ferr)
  );

  always @(negedge clk_line) fall_cnt++;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && (valid || resend)) begin
      if (exp_q.size() == 0) begin
        check(0, "R7/R8 unexpected result", {valid, resend, ferr}, 0);
      end else begin
        exp_t e;
        e = exp_q.pop_front();
        case (e.kind)
          0: begin
            check(valid && !resend && !ferr, "R7 strobe", {valid, resend, ferr}, 3'b100);
            check(rbyte == e.b, "R3 byte", rbyte, e.b);
          end
          1: begin
            check(!valid && resend && !ferr, "R8 parity resend", {valid, resend, ferr}, 3'b010);
            check(rbyte == last_good, "R8 byte held", rbyte, last_good);
          end
          default:
            check(!valid && resend && ferr, "R6 frame resend", {valid, resend, ferr}, 3'b011);
        endcase
      end
    end
  end

  task automatic run_frame(input logic [7:0] b, input bit bad_par, input int e_low);
    logic par;
    int start;
    exp_t it;
    par = ~(^b) ^ bad_par;
    it.b = b;
    it.kind = (e_low > 0) ? 2 : (bad_par ? 1 : 0);
    exp_q.push_back(it);
    host_clk = 1;
    repeat (INH + 5) @(posedge clk);
    host_data = 1;
    repeat (2) @(posedge clk);
    start = fall_cnt;
    host_clk = 0;
    for (int k = 1; k <= 10; k++) begin
      @(negedge clk_line); #1;
      if (k <= 8)      host_data = ~b[k-1];
      else if (k == 9) host_data = ~par;
      else             host_data = (e_low > 0);
      if (k == 5) check(grant == 0, "R9 no grant mid-frame", grant, 0);
    end
    for (int j = 1; j <= e_low; j++) begin
      @(negedge clk_line); #1;
      if (j == e_low) host_data = 0;
    end
    @(negedge clk_line); #1;
    check(data_line == 0, "R5 ack holds DATA low", data_line, 0);
    wait (data_line == 1);
    repeat (5 * HALF) @(posedge clk);
    check(fall_cnt - start == 11 + e_low, "R5/R6 clock count", fall_cnt - start, 11 + e_low);
    check(exp_q.size() == 0, "R7/R8 result seen", exp_q.size(), 0);
    if (it.kind == 0) last_good = b;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", 0, 1);
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(!clk_drv && !data_drv, "R1 lines released", {clk_drv, data_drv}, 0);
    check(!valid && !resend && !ferr && rbyte == 0, "R1 outputs zero",
          {rbyte, valid, resend, ferr}, 0);
    rst_n = 1;
    repeat (5) @(posedge clk);

    tx_req = 1;
    @(negedge clk);
    check(grant == 1, "R9 grant idle", grant, 1);
    host_clk = 1;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(grant == 0, "R9 no grant while inhibited", grant, 0);
    host_clk = 0;
    repeat (4) @(posedge clk);

    // short inhibit: must be ignored
    begin
      int snap;
      host_clk = 1;
      repeat (10) @(posedge clk);
      host_data = 1;
      repeat (2) @(posedge clk);
      snap = fall_cnt;
      host_clk = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check(grant == 0, "R9 no grant with DATA low", grant, 0);
      repeat (100) @(posedge clk);
      check(fall_cnt == snap, "R2 short inhibit ignored", fall_cnt - snap, 0);
      host_data = 0;
      repeat (10) @(posedge clk);
    end

    run_frame(8'hA5, 0, 0);
    run_frame(8'h00, 0, 0);
    run_frame(8'hFF, 0, 0);
    run_frame(8'h01, 0, 0);   // R4 parity bit 0 case
    run_frame(8'h3C, 1, 0);   // R8
    run_frame(8'h5A, 0, 1);   // R6 one low stop clock
    run_frame(8'hC3, 0, 3);   // R6 three low clocks
    run_frame(8'h80, 0, 0);   // R3 MSB position

    @(negedge clk);
    check(grant == 1, "R9 grant after frames", grant, 1);
    check(rbyte == 8'h80, "R7 last byte", rbyte, 8'h80);
    finish_run();
  end
endmodule